// File: doc/BRIEF.md
# Predecrement Stack and Subroutine Sequencer

This unit owns the stack pointer of a small 16-bit machine with a 1024-word memory and sequences every stack-related command through a single-port synchronous memory. The stack grows downward and is full-descending: the pointer starts one past the highest word, so a write first moves the pointer down and then stores, and a read first fetches the word at the pointer and then moves it up.

A command is presented with `cmd_valid_i` while the unit is idle. The unit can push or pop the accumulator, save or restore the index register, call a subroutine, return from one, and copy the stack pointer into the index register. A call stores the return address (the address of the following instruction, given on `pc_i`) and then redirects the program counter to `tgt_i`. A return pops a word and loads its low ten bits into the program counter. Results leave through write strobes (`acc_wr_o`, `idx_wr_o`, `pc_wr_o`) that carry their value in the same cycle, and `done_o` marks the last cycle of every accepted command.

Top module: `stack_call_unit`

## Requirements
- R1: While reset is asserted and after reset, the stack pointer reads 1024 (octal 2000, stack empty), the unit is idle and no strobe or memory write is active.
- R2: Op code 0 (push accumulator), accepted on an edge, causes a memory write in the next cycle at address old pointer minus 1 with the accumulator value sampled at acceptance; `done_o` is high in that cycle and `sp_o` already shows the decremented pointer.
- R3: Op code 1 (pop accumulator) reads the word at the pointer; two cycles after acceptance `done_o` and `acc_wr_o` are high with the top-of-stack word on `acc_o`, and the pointer increments on the following edge.
- R4: Op code 2 saves the index register with the R2 sequence, and op code 3 restores it with the R3 sequence using `idx_wr_o`/`idx_o`; at most one of the three result strobes is high in any cycle.
- R5: Op code 4 (call) writes `pc_i` zero-extended to 16 bits with the R2 sequence and, in the same done cycle, raises `pc_wr_o` with `tgt_i` on `pc_o`.
- R6: Op code 5 (return) follows the R3 sequence and raises `pc_wr_o` with bits 9:0 of the popped word on `pc_o`.
- R7: Op code 6 completes in the cycle after acceptance with `done_o`, `idx_wr_o` and the current pointer zero-extended on `idx_o`; the pointer is unchanged.
- R8: Commands are only accepted while `busy_o` is low; a command held during a busy cycle is ignored, op code 7 is never accepted, and every accepted command raises `done_o` for exactly one cycle.
- R9: A pop-type command (op 1, 3 or 5) with the pointer at 1024 completes in the next cycle with `done_o` only: no result strobe, no write, pointer unchanged.
- R10: A push-type command (op 0, 2 or 4) with the pointer at 0 (stack full) completes in the next cycle with no memory write and the pointer unchanged; a refused call still raises `pc_wr_o` with `tgt_i`.
- R11: The pointer always stays within 0 to 1024 and changes by at most one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command present |
| cmd_op_i | input | 3 | Command code (0..6, 7 reserved) |
| acc_i | input | 16 | Accumulator value to push |
| idx_i | input | 16 | Index register value to save |
| pc_i | input | 10 | Return address for a call |
| tgt_i | input | 10 | Call target address |
| mem_rdata_i | input | 16 | Memory read data, one cycle after address |
| mem_addr_o | output | 10 | Memory address |
| mem_wdata_o | output | 16 | Memory write data |
| mem_we_o | output | 1 | Memory write enable |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | Last cycle of an accepted command |
| acc_wr_o | output | 1 | Accumulator load strobe |
| acc_o | output | 16 | Accumulator load value |
| idx_wr_o | output | 1 | Index register load strobe |
| idx_o | output | 16 | Index register load value |
| pc_wr_o | output | 1 | Program counter load strobe |
| pc_o | output | 10 | Program counter load value |
| sp_o | output | 11 | Current stack pointer |

## Verification
The assertions watch, every cycle, the pointer's range and single-step motion, that a write only happens below the empty mark and right after a decrement, that a pop-to-accumulator is followed by an increment, and that result strobes are exclusive, tied to `done_o` and one cycle long. Whether the right word comes back, in last-in first-out order, whether the full and empty refusals behave, and whether busy-time commands are dropped can only be shown by the bench, whose queue-based model tracks the stack contents and predicts every output cycle by cycle, including a fill to the last word and a drain back to empty.

// File: rtl/stack_call_pkg.sv
package stack_call_pkg;

  typedef enum logic [2:0] {
    OP_PUSH_ACC = 3'd0,
    OP_POP_ACC  = 3'd1,
    OP_PUSH_IDX = 3'd2,
    OP_POP_IDX  = 3'd3,
    OP_CALL     = 3'd4,
    OP_RET      = 3'd5,
    OP_SP_IDX   = 3'd6,
    OP_NONE     = 3'd7
  } stk_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WRITE,
    ST_READ,
    ST_TAKE,
    ST_COPY,
    ST_REFUSE
  } stk_state_e;

  function automatic logic is_push(stk_op_e op);
    return (op == OP_PUSH_ACC) || (op == OP_PUSH_IDX) || (op == OP_CALL);
  endfunction

  function automatic logic is_pop(stk_op_e op);
    return (op == OP_POP_ACC) || (op == OP_POP_IDX) || (op == OP_RET);
  endfunction

endpackage

// File: rtl/stack_ptr.sv
module stack_ptr #(
  parameter int unsigned ADDR_W = 10,
  localparam int unsigned SP_W  = ADDR_W + 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            dec_i,
  input  logic            inc_i,
  output logic [SP_W-1:0] sp_o,
  output logic            empty_o,
  output logic            full_o
);

  localparam logic [SP_W-1:0] SP_EMPTY = {1'b1, {ADDR_W{1'b0}}};

  logic [SP_W-1:0] sp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sp_q <= SP_EMPTY;
    else if (dec_i) sp_q <= sp_q - 1'b1;
    else if (inc_i) sp_q <= sp_q + 1'b1;
  end

  assign sp_o    = sp_q;
  assign empty_o = (sp_q == SP_EMPTY);
  assign full_o  = (sp_q == '0);

endmodule

// File: rtl/stack_operand.sv
module stack_operand
  import stack_call_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  stk_op_e           op_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] idx_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [ADDR_W-1:0] tgt_i,
  output logic [DATA_W-1:0] wdata_o,
  output logic [ADDR_W-1:0] tgt_o
);

  logic [DATA_W-1:0] wdata_d, wdata_q;
  logic [ADDR_W-1:0] tgt_q;

  always_comb begin
    unique case (op_i)
      OP_PUSH_IDX: wdata_d = idx_i;
      OP_CALL:     wdata_d = DATA_W'(pc_i);
      default:     wdata_d = acc_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wdata_q <= '0;
      tgt_q   <= '0;
    end else if (load_i) begin
      wdata_q <= wdata_d;
      tgt_q   <= tgt_i;
    end
  end

  assign wdata_o = wdata_q;
  assign tgt_o   = tgt_q;

endmodule

// File: rtl/stack_seq.sv
module stack_seq
  import stack_call_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    cmd_valid_i,
  input  stk_op_e cmd_op_i,
  input  logic    empty_i,
  input  logic    full_i,
  output logic    accept_o,
  output logic    sp_dec_o,
  output logic    sp_inc_o,
  output logic    mem_we_o,
  output logic    busy_o,
  output logic    done_o,
  output logic    acc_wr_o,
  output logic    idx_wr_o,
  output logic    pc_wr_o,
  output logic    pc_from_mem_o,
  output logic    idx_from_sp_o
);

  stk_state_e state_q, state_d;
  stk_op_e    op_q;

  assign accept_o = (state_q == ST_IDLE) && cmd_valid_i && (cmd_op_i != OP_NONE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (accept_o) begin
          if (is_push(cmd_op_i))     state_d = full_i  ? ST_REFUSE : ST_WRITE;
          else if (is_pop(cmd_op_i)) state_d = empty_i ? ST_REFUSE : ST_READ;
          else                       state_d = ST_COPY;
        end
      end
      ST_READ: state_d = ST_TAKE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      op_q    <= OP_NONE;
    end else begin
      state_q <= state_d;
      if (accept_o) op_q <= cmd_op_i;
    end
  end

  // pointer moves before a write, after a read
  assign sp_dec_o = accept_o && is_push(cmd_op_i) && !full_i;
  assign sp_inc_o = (state_q == ST_TAKE);

  assign mem_we_o      = (state_q == ST_WRITE);
  assign busy_o        = (state_q != ST_IDLE);
  assign done_o        = (state_q == ST_WRITE) || (state_q == ST_TAKE) ||
                         (state_q == ST_COPY)  || (state_q == ST_REFUSE);
  assign acc_wr_o      = (state_q == ST_TAKE) && (op_q == OP_POP_ACC);
  assign idx_from_sp_o = (state_q == ST_COPY);
  assign idx_wr_o      = ((state_q == ST_TAKE) && (op_q == OP_POP_IDX)) || idx_from_sp_o;
  assign pc_from_mem_o = (state_q == ST_TAKE) && (op_q == OP_RET);
  // a refused call still redirects control
  assign pc_wr_o       = pc_from_mem_o ||
                         (((state_q == ST_WRITE) || (state_q == ST_REFUSE)) && (op_q == OP_CALL));

endmodule

// File: rtl/stack_call_unit.sv
module stack_call_unit
  import stack_call_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 10,
  localparam int unsigned SP_W  = ADDR_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [2:0]        cmd_op_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] idx_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [ADDR_W-1:0] tgt_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              mem_we_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              acc_wr_o,
  output logic [DATA_W-1:0] acc_o,
  output logic              idx_wr_o,
  output logic [DATA_W-1:0] idx_o,
  output logic              pc_wr_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic [SP_W-1:0]   sp_o
);

  stk_op_e           op_in;
  logic              accept, sp_dec, sp_inc, empty, full;
  logic              pc_from_mem, idx_from_sp;
  logic [ADDR_W-1:0] tgt_q;

  assign op_in = stk_op_e'(cmd_op_i);

  stack_ptr #(.ADDR_W(ADDR_W)) i_ptr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .dec_i   (sp_dec),
    .inc_i   (sp_inc),
    .sp_o    (sp_o),
    .empty_o (empty),
    .full_o  (full)
  );

  stack_seq i_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .cmd_valid_i   (cmd_valid_i),
    .cmd_op_i      (op_in),
    .empty_i       (empty),
    .full_i        (full),
    .accept_o      (accept),
    .sp_dec_o      (sp_dec),
    .sp_inc_o      (sp_inc),
    .mem_we_o      (mem_we_o),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .acc_wr_o      (acc_wr_o),
    .idx_wr_o      (idx_wr_o),
    .pc_wr_o       (pc_wr_o),
    .pc_from_mem_o (pc_from_mem),
    .idx_from_sp_o (idx_from_sp)
  );

  stack_operand #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_opnd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (accept),
    .op_i    (op_in),
    .acc_i   (acc_i),
    .idx_i   (idx_i),
    .pc_i    (pc_i),
    .tgt_i   (tgt_i),
    .wdata_o (mem_wdata_o),
    .tgt_o   (tgt_q)
  );

  assign mem_addr_o = sp_o[ADDR_W-1:0];
  assign acc_o      = mem_rdata_i;
  assign idx_o      = idx_from_sp ? DATA_W'(sp_o) : mem_rdata_i;
  assign pc_o       = pc_from_mem ? mem_rdata_i[ADDR_W-1:0] : tgt_q;

endmodule

// File: rtl/stack_call_chk.sv
module stack_call_chk #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 10,
  localparam int unsigned SP_W  = ADDR_W + 1
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            mem_we_o,
  input logic            busy_o,
  input logic            done_o,
  input logic            acc_wr_o,
  input logic            idx_wr_o,
  input logic            pc_wr_o,
  input logic [SP_W-1:0] sp_o
);

  localparam logic [SP_W-1:0] SP_EMPTY = {1'b1, {ADDR_W{1'b0}}};

  // R11
  sp_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sp_o <= SP_EMPTY);

  // R11
  sp_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sp_o == $past(sp_o)) || (sp_o == $past(sp_o) + 1'b1) || (sp_o == $past(sp_o) - 1'b1));

  // R2
  push_predec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (sp_o == $past(sp_o) - 1'b1) && (sp_o < SP_EMPTY) && done_o);

  // R3
  pop_postinc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_wr_o |=> (sp_o == $past(sp_o) + 1'b1));

  // R4
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({acc_wr_o, idx_wr_o, pc_wr_o}));

  // R8
  strobe_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_wr_o || idx_wr_o || pc_wr_o) |-> done_o);

  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R8
  done_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);

endmodule

bind stack_call_unit stack_call_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .mem_we_o (mem_we_o),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .acc_wr_o (acc_wr_o),
  .idx_wr_o (idx_wr_o),
  .pc_wr_o  (pc_wr_o),
  .sp_o     (sp_o)
);

// File: tb/test_stack_call_unit.sv
`timescale 1ns/1ps
module test_stack_call_unit;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic [2:0]  cmd_op;
  logic [15:0] acc, idx;
  logic [9:0]  pc, tgt;
  logic [15:0] mem_rdata, mem_wdata, acc_out, idx_out;
  logic [9:0]  mem_addr, pc_out;
  logic        mem_we, busy, done, acc_wr, idx_wr, pc_wr;
  logic [10:0] sp;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  stack_call_unit i_stack_call_unit (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .acc_i(acc), .idx_i(idx), .pc_i(pc), .tgt_i(tgt), .mem_rdata_i(mem_rdata),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_we_o(mem_we),
    .busy_o(busy), .done_o(done), .acc_wr_o(acc_wr), .acc_o(acc_out),
    .idx_wr_o(idx_wr), .idx_o(idx_out), .pc_wr_o(pc_wr), .pc_o(pc_out), .sp_o(sp)
  );

  // single-port synchronous memory, one cycle read latency
  logic [15:0] mem [1024];
  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  // reference model: 0 idle, 1 write, 2 read, 3 take, 4 copy, 5 refuse
  int          m_phase;
  logic [2:0]  m_op;
  logic [10:0] m_sp;
  logic [15:0] m_wd;
  logic [9:0]  m_tgt;
  logic [15:0] q[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0; m_op = 3'd7; m_sp = 11'd1024; m_wd = '0; m_tgt = '0; q.delete();
    end else begin
      case (m_phase)
        0: if (cmd_valid && cmd_op != 3'd7) begin
          m_op = cmd_op; m_tgt = tgt;
          m_wd = (cmd_op == 3'd2) ? idx : (cmd_op == 3'd4) ? {6'b0, pc} : acc;
          if (cmd_op == 3'd0 || cmd_op == 3'd2 || cmd_op == 3'd4) begin
            if (m_sp == 11'd0) m_phase = 5;
            else begin m_sp = m_sp - 11'd1; m_phase = 1; end
          end else if (cmd_op == 3'd6) m_phase = 4;
          else m_phase = (m_sp == 11'd1024) ? 5 : 2;
        end
        1: begin q.push_back(m_wd); m_phase = 0; end
        2: m_phase = 3;
        3: begin void'(q.pop_back()); m_sp = m_sp + 11'd1; m_phase = 0; end
        default: m_phase = 0;
      endcase
    end
  end

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %0h expected %0h", r, $time, act, exp);
    end
  endtask

  function automatic string req_of();
    if (m_phase == 0) return "R8";
    if (m_phase == 5) return (m_op == 3'd1 || m_op == 3'd3 || m_op == 3'd5) ? "R9" : "R10";
    case (m_op)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2, 3'd3: return "R4";
      3'd4: return "R5";
      3'd5: return "R6";
      default: return "R7";
    endcase
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      string r;
      logic e_done, e_acc, e_idx, e_pc;
      logic [15:0] top, e_idx_v;
      logic [9:0] e_pc_v;
      r = req_of();
      top = (q.size() > 0) ? q[$] : 16'h0;
      e_done = (m_phase == 1) || (m_phase == 3) || (m_phase == 4) || (m_phase == 5);
      e_acc  = (m_phase == 3) && (m_op == 3'd1);
      e_idx  = ((m_phase == 3) && (m_op == 3'd3)) || (m_phase == 4);
      e_pc   = ((m_phase == 1 || m_phase == 5) && m_op == 3'd4) || (m_phase == 3 && m_op == 3'd5);
      e_idx_v = (m_phase == 4) ? {5'b0, m_sp} : top;
      e_pc_v  = (m_op == 3'd5) ? top[9:0] : m_tgt;
      chk(sp == m_sp, "R11", 32'(sp), 32'(m_sp));
      chk(busy == (m_phase != 0), "R8", 32'(busy), 32'(m_phase != 0));
      chk(done == e_done, r, 32'(done), 32'(e_done));
      chk(mem_we == (m_phase == 1), r, 32'(mem_we), 32'(m_phase == 1));
      if (m_phase == 1) begin
        chk(mem_addr == m_sp[9:0], r, 32'(mem_addr), 32'(m_sp[9:0]));
        chk(mem_wdata == m_wd, r, 32'(mem_wdata), 32'(m_wd));
      end
      chk(acc_wr == e_acc, r, 32'(acc_wr), 32'(e_acc));
      if (e_acc) chk(acc_out == top, "R3", 32'(acc_out), 32'(top));
      chk(idx_wr == e_idx, r, 32'(idx_wr), 32'(e_idx));
      if (e_idx) chk(idx_out == e_idx_v, r, 32'(idx_out), 32'(e_idx_v));
      chk(pc_wr == e_pc, r, 32'(pc_wr), 32'(e_pc));
      if (e_pc) chk(pc_out == e_pc_v, r, 32'(pc_out), 32'(e_pc_v));
    end
  end

  task automatic send(input logic [2:0] op, input logic [15:0] a, input logic [15:0] x,
                      input logic [9:0] p, input logic [9:0] t, input bit poke);
    @(posedge clk); #1;
    cmd_valid = 1'b1; cmd_op = op; acc = a; idx = x; pc = p; tgt = t;
    @(posedge clk); #1;
    if (poke) begin  // R8: a second command while busy must be dropped
      cmd_op = 3'd0; acc = ~a;
      @(posedge clk); #1;
    end
    cmd_valid = 1'b0;
    while (m_phase != 0) begin @(posedge clk); #1; end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL R8 watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = '0; acc = '0; idx = '0; pc = '0; tgt = '0;
    #12;
    // R1 reset state
    chk(sp == 11'd1024, "R1", 32'(sp), 32'd1024);
    chk(!done && !mem_we && !busy, "R1", {29'b0, done, mem_we, busy}, 32'd0);
    chk(!acc_wr && !idx_wr && !pc_wr, "R1", {29'b0, acc_wr, idx_wr, pc_wr}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    chk(sp == 11'd1024, "R1", 32'(sp), 32'd1024);

    send(3'd1, 0, 0, 0, 0, 0);             // R9 pop acc on empty
    send(3'd5, 0, 0, 0, 0, 0);             // R9 return on empty
    send(3'd7, 16'h1234, 0, 0, 0, 0);      // R8 reserved op
    send(3'd0, 16'h8001, 0, 0, 0, 0);      // R2
    send(3'd0, 16'h7ffe, 0, 0, 0, 0);      // R2
    send(3'd2, 0, 16'h0a5a, 0, 0, 0);      // R4 save index
    send(3'd6, 0, 0, 0, 0, 0);             // R7 copy pointer
    send(3'd3, 0, 0, 0, 0, 1);             // R4 restore, R8 poke while busy
    send(3'd1, 0, 0, 0, 0, 0);             // R3
    send(3'd4, 0, 0, 10'h123, 10'h300, 0); // R5 call
    send(3'd4, 0, 0, 10'h301, 10'h050, 1); // R5 nested call, R8 poke
    send(3'd5, 0, 0, 0, 0, 0);             // R6
    send(3'd0, 16'hfc05, 0, 0, 0, 0);      // R2 word whose low bits look like a target
    send(3'd5, 0, 0, 0, 0, 0);             // R6 low ten bits only
    send(3'd5, 0, 0, 0, 0, 0);             // R6
    send(3'd1, 0, 0, 0, 0, 0);             // R3
    // fill to full
    for (int i = 0; i < 1024; i++) send(3'd0, 16'(i * 37 + 5), 0, 0, 0, 0);
    send(3'd0, 16'hbeef, 0, 0, 0, 0);      // R10 push on full
    send(3'd4, 0, 0, 10'h011, 10'h2aa, 0); // R10 call on full still jumps
    send(3'd2, 0, 16'h4444, 0, 0, 0);      // R10 save index on full
    send(3'd6, 0, 0, 0, 0, 0);             // R7 pointer is zero
    // drain back to empty
    for (int i = 0; i < 1024; i++) send((i % 2 == 0) ? 3'd1 : 3'd3, 0, 0, 0, 0, 0);
    send(3'd3, 0, 0, 0, 0, 0);             // R9 restore on empty
    send(3'd6, 0, 0, 0, 0, 0);             // R7
    repeat (3) @(posedge clk);
    @(negedge clk);
    finish_run();
  end

endmodule